// File: doc/BRIEF.md
# Byte-wide slave configuration receiver

This block accepts a configuration stream one byte at a time from an external controller over a strobed parallel port. The port has four kinds of input: an active-low select, an active-low write enable, a configuration strobe and an 8-bit data bus. All of them are asynchronous to the block. A system clock at least four times faster than the strobe samples them through two-flop synchronisers. The block finds strobe rising edges in the sampled stream. It captures a byte on each rising edge that qualifies and hands the byte on with a one-cycle valid pulse. It also counts the accepted bytes.

Two protocol violations abort configuration. The first is the write enable being inactive (high) at a strobe rising edge while select is active. The second is the write enable changing level during the strobe's low phase while select is active; this aborts at the next rising edge. An abort is a sticky flag. Once it is set, no further bytes are accepted until synchronous reset.

A small controller can drive the port with no glue logic. Its write strobe goes to the strobe input, its chip-select output goes to the write enable, and a spare output pin goes to select. Each bus write then ends in one strobe rising edge. The write enable moves only while the strobe is high, so these writes never trip the toggle rule.

Top module: `slave_cfg_port`

## Requirements
- R1: After reset, `byte_vld` is 0, `cfg_abort` is 0 and `byte_count` is 0.
- R2: A strobe rising edge seen while `cfg_sel_n`=0 and `cfg_wr_n`=0 produces a single-cycle `byte_vld` pulse, with `byte_data` equal to the value on `cfg_data` at that edge.
- R3: While `cfg_sel_n`=1, strobe transitions are ignored: no byte is captured and no abort is raised.
- R4: `byte_count` increases by exactly one in each cycle that `byte_vld` is 1 and holds its value in every other cycle.
- R5: A strobe rising edge with `cfg_sel_n`=0 and `cfg_wr_n`=1 sets `cfg_abort` and captures no byte.
- R6: A change of `cfg_wr_n` while the strobe is low and `cfg_sel_n`=0 sets `cfg_abort` at the next strobe rising edge, even if `cfg_wr_n` is back to 0 by then, and that edge captures no byte.
- R7: Changes of `cfg_wr_n` made while the strobe is high, or while `cfg_sel_n`=1, are not recorded. A controller-style write, where the write enable falls before the strobe falls and rises after the strobe rises, is accepted.
- R8: `cfg_abort` stays set once raised. While it is set, no `byte_vld` is produced and `byte_count` is frozen.
- R9: A synchronous reset after an abort clears `cfg_abort` and `byte_count`, and capture works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel_n | input | 1 | Port select, active low, asynchronous |
| cfg_wr_n | input | 1 | Write enable, active low, asynchronous |
| cfg_strobe | input | 1 | Configuration strobe; bytes are taken on its rising edge |
| cfg_data | input | 8 | Configuration data byte |
| byte_vld | output | 1 | One-cycle pulse marking a captured byte |
| byte_data | output | 8 | Captured byte, valid while `byte_vld` is 1 |
| cfg_abort | output | 1 | Sticky abort flag |
| byte_count | output | 32 | Number of bytes accepted since reset |

## Verification
The hardest case to reach is the toggle abort. The write enable has to leave its active level and come back, all inside one strobe low phase with select held low, so that at the edge the level check alone sees a perfectly legal state. The bench builds this with a directed sequence. It lowers the strobe, pulses the write enable high for several system clocks, restores it to low, and only then raises the strobe. Two contrasting sequences run against it. In one, the write enable toggles while the strobe is high, which is how the controller-style writes in the vector table behave. In the other, it toggles while select is high. Both must be accepted.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int DW = 8;

    // One sampled snapshot of the port pins
    typedef struct packed {
        logic          sel_n;
        logic          wr_n;
        logic          strobe;
        logic [DW-1:0] data;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // Idle pin state used as the synchroniser reset value
    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, strobe: 1'b1, data: '0};

    // Outcome of evaluating one strobe rising edge
    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_TAKE      = 2'd1,
        EV_ABORT_LVL = 2'd2,
        EV_ABORT_TGL = 2'd3
    } verdict_t;

    function automatic verdict_t judge_edge(input logic wr_n_now,
                                            input logic toggled);
        if (wr_n_now)
            return EV_ABORT_LVL;
        else if (toggled)
            return EV_ABORT_TGL;
        else
            return EV_TAKE;
    endfunction

    function automatic logic is_abort(input verdict_t v);
        return (v == EV_ABORT_LVL) || (v == EV_ABORT_TGL);
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spc_detect.sv
module spc_detect
    import spc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pins_t         smp,
    output logic          strobe_rise,
    output verdict_t      verdict,
    output logic [DW-1:0] edge_data
);

    logic prv_strobe;
    logic prv_wr_n;
    logic tgl_q;
    logic tgl_d;
    logic wr_chg;
    logic sel_act;

    assign sel_act     = ~smp.sel_n;
    assign strobe_rise = smp.strobe & ~prv_strobe;
    assign wr_chg      = smp.wr_n ^ prv_wr_n;
    assign edge_data   = smp.data;

    // Toggle record: only changes during the strobe low phase with select active
    always_comb begin
        tgl_d = tgl_q;
        if (!sel_act)
            tgl_d = 1'b0;
        else if (strobe_rise)
            tgl_d = 1'b0;
        else if (wr_chg && !smp.strobe)
            tgl_d = 1'b1;
    end

    always_comb begin
        verdict = EV_NONE;
        if (strobe_rise && sel_act)
            verdict = judge_edge(smp.wr_n, tgl_q | wr_chg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_strobe <= PINS_IDLE.strobe;
            prv_wr_n   <= PINS_IDLE.wr_n;
            tgl_q      <= 1'b0;
        end else begin
            prv_strobe <= smp.strobe;
            prv_wr_n   <= smp.wr_n;
            tgl_q      <= tgl_d;
        end
    end

endmodule

// File: rtl/spc_capture.sv
module spc_capture
    import spc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  verdict_t         verdict,
    input  logic [DW-1:0]    edge_data,
    output logic             byte_vld,
    output logic [DW-1:0]    byte_data,
    output logic             aborted,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_vld  <= 1'b0;
            byte_data <= '0;
            aborted   <= 1'b0;
            count     <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!aborted) begin
                if (verdict == EV_TAKE) begin
                    byte_vld  <= 1'b1;
                    byte_data <= edge_data;
                    count     <= count + CNT_W'(1);
                end else if (is_abort(verdict)) begin
                    aborted <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slave_cfg_port.sv
module slave_cfg_port
    import spc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_sel_n,
    input  logic             cfg_wr_n,
    input  logic             cfg_strobe,
    input  logic [DW-1:0]    cfg_data,
    output logic             byte_vld,
    output logic [DW-1:0]    byte_data,
    output logic             cfg_abort,
    output logic [CNT_W-1:0] byte_count
);

    pins_t         raw;
    pins_t         smp;
    logic [PINS_W-1:0] smp_bits;
    logic          strobe_rise;
    verdict_t      verdict;
    logic [DW-1:0] edge_data;

    assign raw = '{sel_n: cfg_sel_n, wr_n: cfg_wr_n, strobe: cfg_strobe, data: cfg_data};

    spc_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (smp_bits)
    );

    assign smp = pins_t'(smp_bits);

    spc_detect u_det (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .strobe_rise (strobe_rise),
        .verdict     (verdict),
        .edge_data   (edge_data)
    );

    spc_capture #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .edge_data (edge_data),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .aborted   (cfg_abort),
        .count     (byte_count)
    );

endmodule

// File: rtl/slave_cfg_port_chk.sv
module slave_cfg_port_chk
    import spc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input pins_t            smp,
    input logic             strobe_rise,
    input logic             byte_vld,
    input logic             cfg_abort,
    input logic [CNT_W-1:0] byte_count
);

    p_abort_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_abort |=> cfg_abort);

    p_no_vld_aborted_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_abort) |-> !byte_vld);

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> byte_count == $past(byte_count) + CNT_W'(1));

    p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> $stable(byte_count));

    p_vld_needs_sel_r3: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(!smp.sel_n && !smp.wr_n && strobe_rise));

    p_level_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise && !smp.sel_n && smp.wr_n) |=> (cfg_abort && !byte_vld));

endmodule

bind slave_cfg_port slave_cfg_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp         (smp),
    .strobe_rise (strobe_rise),
    .byte_vld    (byte_vld),
    .cfg_abort   (cfg_abort),
    .byte_count  (byte_count)
);

// File: tb/slave_cfg_port_bench.sv
module slave_cfg_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        strobe = 1'b1;
    logic [7:0]  data = 8'h00;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        cfg_abort;
    logic [31:0] byte_count;

    int errors = 0;
    int checks = 0;
    int nvld = 0;
    logic [7:0] last_byte = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slave_cfg_port u_slave_cfg_port (
        .clk        (clk),
        .rst        (rst),
        .cfg_sel_n  (sel_n),
        .cfg_wr_n   (wr_n),
        .cfg_strobe (strobe),
        .cfg_data   (data),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .cfg_abort  (cfg_abort),
        .byte_count (byte_count)
    );

    // Byte monitor sampled at the falling clock edge
    always @(negedge clk) begin
        if (!rst && byte_vld) begin
            nvld      <= nvld + 1;
            last_byte <= byte_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mcu_write(input logic [7:0] d);
        data = d; wr_n = 1'b0; w(4);
        strobe = 1'b0; w(4);
        strobe = 1'b1; w(4);
        wr_n = 1'b1; w(4);
    endtask

    task automatic held_write(input logic [7:0] d);
        data = d; wr_n = 1'b0; w(4);
        strobe = 1'b0; w(4);
        strobe = 1'b1; w(8);
    endtask

    task automatic idle_pulse(input logic [7:0] d);
        sel_n = 1'b1; data = d; w(4);
        strobe = 1'b0; w(4);
        strobe = 1'b1; w(4);
        sel_n = 1'b0; w(4);
    endtask

    task automatic do_reset();
        sel_n = 1'b1; wr_n = 1'b1; strobe = 1'b1;
        rst = 1'b1; w(4);
        rst = 1'b0; w(2);
    endtask

    typedef struct packed {
        logic [1:0] kind;   // 0 controller write, 1 held-low write, 2 deselected pulse
        logic [7:0] d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{kind: 2'd0, d: 8'hA5},
        '{kind: 2'd0, d: 8'h3C},
        '{kind: 2'd2, d: 8'hFF},
        '{kind: 2'd1, d: 8'h00},
        '{kind: 2'd1, d: 8'h81},
        '{kind: 2'd2, d: 8'h42},
        '{kind: 2'd0, d: 8'h7E},
        '{kind: 2'd1, d: 8'hC3}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int exp_cnt;
        int exp_vld;
        logic [7:0] exp_byte;

        do_reset();
        // R1 reset state
        chk("R1 byte_vld", byte_vld, 0);
        chk("R1 cfg_abort", cfg_abort, 0);
        chk("R1 byte_count", byte_count, 0);

        sel_n = 1'b0; w(4);
        exp_cnt = 0; exp_vld = 0; exp_byte = 8'h00;
        for (int i = 0; i < 8; i++) begin
            case (VECS[i].kind)
                2'd0: begin mcu_write(VECS[i].d); exp_cnt++; exp_vld++; exp_byte = VECS[i].d; end
                2'd1: begin held_write(VECS[i].d); exp_cnt++; exp_vld++; exp_byte = VECS[i].d; end
                default: idle_pulse(VECS[i].d);
            endcase
            // R2 data, R3 deselected ignored, R4 count, R7 controller writes accepted
            chk("R2 R3 pulse count", nvld, exp_vld);
            chk("R2 R7 byte value", last_byte, exp_byte);
            chk("R4 byte_count", byte_count, exp_cnt);
            chk("R3 R7 no abort", cfg_abort, 0);
        end

        // R7: toggle while deselected is forgotten
        wr_n = 1'b0; w(4);
        sel_n = 1'b1; w(2);
        strobe = 1'b0; w(4);
        wr_n = 1'b1; w(4);
        wr_n = 1'b0; w(4);
        sel_n = 1'b0; data = 8'h5A; w(4);
        strobe = 1'b1; w(8);
        chk("R7 deselected toggle ignored abort", cfg_abort, 0);
        chk("R7 deselected toggle byte", last_byte, 8'h5A);

        // R6: toggle during strobe low aborts at next edge
        exp_vld = nvld;
        wr_n = 1'b0; data = 8'h99; w(4);
        strobe = 1'b0; w(4);
        wr_n = 1'b1; w(4);
        wr_n = 1'b0; w(4);
        chk("R6 no abort before edge", cfg_abort, 0);
        strobe = 1'b1; w(8);
        chk("R6 toggle abort", cfg_abort, 1);
        chk("R6 no byte on abort edge", nvld, exp_vld);

        // R8: sticky, no capture, count frozen
        held_write(8'h11);
        chk("R8 abort held", cfg_abort, 1);
        chk("R8 no byte after abort", nvld, exp_vld);
        chk("R8 count frozen", byte_count, exp_cnt + 1);

        // R9: reset restores operation
        do_reset();
        chk("R9 abort cleared", cfg_abort, 0);
        chk("R9 count cleared", byte_count, 0);
        sel_n = 1'b0; w(4);
        mcu_write(8'hE7);
        chk("R9 capture after reset", last_byte, 8'hE7);
        chk("R9 count after reset", byte_count, 1);

        // R5: write enable high at edge with select active
        exp_vld = nvld;
        wr_n = 1'b1; w(4);
        strobe = 1'b0; w(4);
        strobe = 1'b1; w(8);
        chk("R5 level abort", cfg_abort, 1);
        chk("R5 no byte", nvld, exp_vld);
        chk("R5 count unchanged", byte_count, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule